// File: doc/BRIEF.md
# Dual-Rate LED Blinker with Register Port

This block controls up to sixteen open-drain LED pins. Every pin has a two-bit source code held in a selector register. The code either pulls the pin low so the LED lights, releases the pin so the LED stays dark, or hands the pin to one of two shared blink channels. Each blink channel has two settings. An eight-bit prescaler sets how long the blink period lasts. An eight-bit duty value sets the point in that period where the channel turns on. Both channels take their timing from one tick at 9728 Hz, which the block divides down from the system clock.

Software reaches the block through a byte-wide register port. The port has a write strobe, an address and write data, and read data returns one cycle after the address. Every pin level is also synchronised back into input registers, so a released pin can be used as a general-purpose input. The register port is a control interface, so it has no valid/ready handshake: a write takes effect on the clock edge where `reg_we` is high, and a read never stalls.

Top module: `led_blink_regs`

## Requirements
- R1: The two-bit source code of a pin selects what drives it. Code 0 sets `drv_low` to 1 (LED lit). Code 1 sets it to 0 (pin released). Code 2 follows blink channel 0 and code 3 follows blink channel 1.
- R2: The source code of pin n sits in bits [2*(n mod 4)+1 : 2*(n mod 4)] of selector register n/4. A write to that register changes only the pins it holds.
- R3: With NIN = ceil(NUM_LEDS/8), input registers sit at addresses 0..NIN-1. Address NIN holds prescaler 0, NIN+1 duty 0, NIN+2 prescaler 1 and NIN+3 duty 1. The selector registers start at NIN+4.
- R4: Any address above the last selector register reads as 0, and a write to it changes no register and no output.
- R5: A blink tick occurs once every CLK_HZ/9728 clock cycles.
- R6: The phase of a channel steps through 256 values, and each step lasts prescaler+1 ticks. The channel is on while the phase is at or above its duty value, so it is on for (256-duty)/256 of each period. A duty of 0 means always on.
- R7: Input register r bit b reads the level of pin 8r+b after a two-flop synchroniser. Bits for pins that do not exist read 0.
- R8: After reset, every source code is 1, both prescalers are 0, both duty values are 0x80, and `drv_low` is all zero.
- R9: `reg_rdata` shows the register addressed by `reg_addr` in the previous cycle.
- R10: `drv_low` is registered: it reflects the source codes and channel states of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address for reads and writes |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data, one cycle after the address |
| pin_in | input | NUM_LEDS | Sensed pin levels |
| drv_low | output | NUM_LEDS | Pull-low enable per pin (1 = drive low) |

## Verification
A wrong phase or prescaler count in a channel does not appear in one sample. It shows as a wrong number of lit cycles across a full blink period, which takes up to 256×(prescaler+1) ticks to become visible. A wrong source code or a misplaced selector field shows at `drv_low` two cycles after the write. A corrupted register shows on `reg_rdata` one cycle after that address is presented. The bench therefore compares every cycle against a behavioural model and also counts lit cycles over whole periods.

// File: rtl/led_blink_pkg.sv
package led_blink_pkg;
  localparam int unsigned TICK_HZ = 38 * 256;
  typedef enum logic [1:0] {
    SRC_ON  = 2'd0,
    SRC_OFF = 2'd1,
    SRC_CH0 = 2'd2,
    SRC_CH1 = 2'd3
  } src_e;
endpackage

// File: rtl/blink_tick_gen.sv
module blink_tick_gen #(
  parameter int unsigned DIV = 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/blink_channel.sv
module blink_channel (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [7:0] psc,
  input  logic [7:0] duty,
  output logic [7:0] phase,
  output logic       active
);
  logic [7:0] pcnt_q;
  logic [7:0] phase_q;

  // each phase step lasts psc+1 ticks; the count reloads when it runs out
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q  <= '0;
      phase_q <= '0;
    end else if (tick) begin
      if (pcnt_q == 8'd0) begin
        pcnt_q  <= psc;
        phase_q <= phase_q + 8'd1;
      end else begin
        pcnt_q <= pcnt_q - 8'd1;
      end
    end
  end

  assign phase  = phase_q;
  assign active = (phase_q >= duty);
endmodule

// File: rtl/led_reg_bank.sv
module led_reg_bank #(
  parameter int unsigned NUM_LEDS = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [7:0]            addr,
  input  logic [7:0]            wdata,
  input  logic [NUM_LEDS-1:0]   pins_sync,
  output logic [7:0]            rdata,
  output logic [1:0][7:0]       psc,
  output logic [1:0][7:0]       duty,
  output logic [2*NUM_LEDS-1:0] sel_flat
);
  localparam int unsigned NIN   = (NUM_LEDS + 7) / 8;
  localparam int unsigned NSEL  = (NUM_LEDS + 3) / 4;
  localparam int unsigned A_CH  = NIN;
  localparam int unsigned A_LS  = NIN + 4;
  localparam int unsigned PINW  = 8 * NIN;
  localparam int unsigned SELW  = 8 * NSEL;

  logic [1:0][7:0]       psc_q, duty_q;
  logic [2*NUM_LEDS-1:0] sel_q;
  logic [PINW-1:0]       pin_pad;
  logic [SELW-1:0]       sel_pad;
  logic [7:0]            rd_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q  <= '0;
      duty_q <= {2{8'h80}};
      sel_q  <= {NUM_LEDS{2'b01}};
    end else if (we) begin
      for (int c = 0; c < 2; c++) begin
        if (addr == 8'(A_CH + 2 * c))     psc_q[c]  <= wdata;
        if (addr == 8'(A_CH + 2 * c + 1)) duty_q[c] <= wdata;
      end
      for (int n = 0; n < NUM_LEDS; n++) begin
        if (addr == 8'(A_LS + n / 4)) sel_q[2*n +: 2] <= wdata[2*(n%4) +: 2];
      end
    end
  end

  assign pin_pad = PINW'(pins_sync);
  assign sel_pad = SELW'(sel_q);

  always_comb begin
    rd_c = '0;
    for (int r = 0; r < NIN; r++)
      if (addr == 8'(r)) rd_c = pin_pad[8*r +: 8];
    for (int c = 0; c < 2; c++) begin
      if (addr == 8'(A_CH + 2 * c))     rd_c = psc_q[c];
      if (addr == 8'(A_CH + 2 * c + 1)) rd_c = duty_q[c];
    end
    for (int s = 0; s < NSEL; s++)
      if (addr == 8'(A_LS + s)) rd_c = sel_pad[8*s +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd_c;
  end

  assign psc      = psc_q;
  assign duty     = duty_q;
  assign sel_flat = sel_q;
endmodule

// File: rtl/led_blink_regs.sv
module led_blink_regs
  import led_blink_pkg::*;
#(
  parameter int unsigned NUM_LEDS = 16,
  parameter int unsigned CLK_HZ   = 100_000_000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [7:0]          reg_addr,
  input  logic [7:0]          reg_wdata,
  output logic [7:0]          reg_rdata,
  input  logic [NUM_LEDS-1:0] pin_in,
  output logic [NUM_LEDS-1:0] drv_low
);
  localparam int unsigned DIV_RAW = CLK_HZ / TICK_HZ;
  localparam int unsigned DIV     = (DIV_RAW == 0) ? 1 : DIV_RAW;

  logic                  tick;
  logic [NUM_LEDS-1:0]   sync1_q, sync2_q;
  logic [1:0][7:0]       psc, duty, ch_phase;
  logic [1:0]            ch_act;
  logic [2*NUM_LEDS-1:0] sel_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
    end
  end

  blink_tick_gen #(.DIV(DIV)) tick_i (.clk(clk), .rst_n(rst_n), .tick(tick));

  for (genvar c = 0; c < 2; c++) begin : g_ch
    blink_channel ch_i (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .psc(psc[c]), .duty(duty[c]),
      .phase(ch_phase[c]), .active(ch_act[c])
    );
  end

  led_reg_bank #(.NUM_LEDS(NUM_LEDS)) regs_i (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .pins_sync(sync2_q), .rdata(reg_rdata), .psc(psc), .duty(duty),
    .sel_flat(sel_flat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drv_low <= '0;
    else begin
      for (int n = 0; n < NUM_LEDS; n++) begin
        case (src_e'(sel_flat[2*n +: 2]))
          SRC_ON:  drv_low[n] <= 1'b1;
          SRC_OFF: drv_low[n] <= 1'b0;
          SRC_CH0: drv_low[n] <= ch_act[0];
          default: drv_low[n] <= ch_act[1];
        endcase
      end
    end
  end
endmodule

// File: rtl/led_blink_chk.sv
module led_blink_chk #(
  parameter int unsigned NUM_LEDS = 16,
  parameter int unsigned CLK_HZ   = 100_000_000
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [7:0]            reg_addr,
  input logic [7:0]            reg_rdata,
  input logic [NUM_LEDS-1:0]   drv_low,
  input logic [2*NUM_LEDS-1:0] sel_flat,
  input logic                  tick,
  input logic [1:0][7:0]       ch_phase
);
  localparam int unsigned NIN  = (NUM_LEDS + 7) / 8;
  localparam int unsigned NSEL = (NUM_LEDS + 3) / 4;
  localparam int unsigned LAST = NIN + 4 + NSEL - 1;
  localparam int unsigned DIV  = (CLK_HZ / (38 * 256) == 0) ? 1 : CLK_HZ / (38 * 256);

  // R4
  out_of_range_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr > 8'(LAST)) |=> (reg_rdata == 8'h00));

  for (genvar n = 0; n < NUM_LEDS; n++) begin : g_pin
    // R1
    src_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_flat[2*n +: 2] == 2'b00) |=> drv_low[n]);
    // R1
    src_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_flat[2*n +: 2] == 2'b01) |=> !drv_low[n]);
  end

  // R6
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(ch_phase));

  if (DIV > 1) begin : g_gap
    // R5
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
  end
endmodule

bind led_blink_regs led_blink_chk #(.NUM_LEDS(NUM_LEDS), .CLK_HZ(CLK_HZ)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .drv_low(drv_low), .sel_flat(sel_flat), .tick(tick), .ch_phase(ch_phase)
);

// File: tb/led_blink_regs_tb_top.sv
`timescale 1ns/1ps
module led_blink_regs_tb_top;
  localparam int NL     = 16;
  localparam int CLK_HZ = 9728 * 3;
  localparam int DIV    = CLK_HZ / 9728;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [7:0]    reg_addr = '0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;
  logic [NL-1:0] ext_lvl = '1;
  logic [NL-1:0] pin_in;
  logic [NL-1:0] drv_low;

  int compared = 0;
  int mismatched = 0;

  always #2 clk = ~clk;

  assign pin_in = ext_lvl & ~drv_low;

  led_blink_regs #(.NUM_LEDS(NL), .CLK_HZ(CLK_HZ)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in), .drv_low(drv_low)
  );

  // behavioural reference
  int m_div, m_pc[2], m_ph[2], m_psc[2], m_pwm[2], m_sel[NL];
  logic [NL-1:0] m_s1, m_s2, exp_drv;
  logic [7:0] exp_rd;
  bit live = 0;

  function automatic logic [7:0] m_read(int a);
    logic [7:0] v = '0;
    if (a < 2) v = m_s2[a*8 +: 8];
    else if (a == 2) v = 8'(m_psc[0]);
    else if (a == 3) v = 8'(m_pwm[0]);
    else if (a == 4) v = 8'(m_psc[1]);
    else if (a == 5) v = 8'(m_pwm[1]);
    else if (a <= 9) for (int k = 0; k < 4; k++) v[2*k +: 2] = 2'(m_sel[4*(a-6)+k]);
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_div = 0; live = 0; m_s1 = '0; m_s2 = '0;
      for (int c = 0; c < 2; c++) begin m_pc[c] = 0; m_ph[c] = 0; m_psc[c] = 0; m_pwm[c] = 128; end
      for (int n = 0; n < NL; n++) m_sel[n] = 1;
    end else begin
      for (int n = 0; n < NL; n++) begin
        case (m_sel[n])
          0: exp_drv[n] = 1'b1;
          1: exp_drv[n] = 1'b0;
          2: exp_drv[n] = (m_ph[0] >= m_pwm[0]);
          default: exp_drv[n] = (m_ph[1] >= m_pwm[1]);
        endcase
      end
      exp_rd = m_read(int'(reg_addr));
      if (m_div == DIV - 1)
        for (int c = 0; c < 2; c++)
          if (m_pc[c] == 0) begin m_pc[c] = m_psc[c]; m_ph[c] = (m_ph[c] + 1) % 256; end
          else m_pc[c] = m_pc[c] - 1;
      m_div = (m_div == DIV - 1) ? 0 : m_div + 1;
      m_s2 = m_s1; m_s1 = pin_in;
      if (reg_we) begin
        case (reg_addr)
          8'd2: m_psc[0] = reg_wdata;
          8'd3: m_pwm[0] = reg_wdata;
          8'd4: m_psc[1] = reg_wdata;
          8'd5: m_pwm[1] = reg_wdata;
          default: if (reg_addr >= 6 && reg_addr <= 9)
            for (int k = 0; k < 4; k++) m_sel[4*(reg_addr-6)+k] = reg_wdata[2*k +: 2];
        endcase
      end
      live = 1;
    end
  end

  always @(negedge clk) begin
    if (live) begin
      compared++;
      if (drv_low !== exp_drv) begin
        mismatched++;
        $display("FAIL R10 drv_low actual %h expected %h", drv_low, exp_drv);
      end
      compared++;
      if (reg_rdata !== exp_rd) begin
        mismatched++;
        $display("FAIL R9 reg_rdata actual %h expected %h", reg_rdata, exp_rd);
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); reg_we = 1'b1; reg_addr = 8'(a); reg_wdata = 8'(d);
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(int a, int exp, string tag);
    reg_addr = 8'(a);
    @(negedge clk);
    check(tag, int'(reg_rdata), exp);
  endtask

  task automatic on_count(int pin, int ncyc, int exp, string tag);
    int cnt = 0;
    repeat (ncyc) begin @(negedge clk); cnt += int'(drv_low[pin]); end
    check(tag, cnt, exp);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset values, located per R3
    check("R8 drv_low", int'(drv_low), 0);
    rd(2, 8'h00, "R8 psc0"); rd(3, 8'h80, "R8 duty0");
    rd(4, 8'h00, "R8 psc1"); rd(5, 8'h80, "R8 duty1");
    for (int a = 6; a <= 9; a++) rd(a, 8'h55, "R8 selector");
    // R4 out-of-range
    wr(10, 8'hFF); wr(8'hC8, 8'hFF);
    rd(10, 0, "R4 read 10"); rd(8'hC8, 0, "R4 read C8");
    rd(6, 8'h55, "R4 sel untouched"); rd(3, 8'h80, "R4 duty untouched");
    check("R4 drv_low", int'(drv_low), 0);
    // R1 codes
    wr(6, 8'hE4);
    repeat (2) @(negedge clk);
    check("R1 code0 pin0", int'(drv_low[0]), 1);
    check("R1 code1 pin1", int'(drv_low[1]), 0);
    // R2 field position
    wr(7, 8'h51);
    repeat (2) @(negedge clk);
    check("R2 pin5 on", int'(drv_low[5]), 1);
    check("R2 pin4 off", int'(drv_low[4]), 0);
    rd(7, 8'h51, "R3 selector 1 readback");
    // R6 duty 0 always on
    wr(3, 0);
    repeat (3) @(negedge clk);
    on_count(2, 768, 768, "R6 duty0 always on");
    // R5 R6 channel 1 at duty 0x40, prescaler 0: 256 ticks of 3 cycles
    wr(5, 8'h40);
    repeat (3) @(negedge clk);
    on_count(3, 768, 576, "R5 R6 duty 0x40");
    wr(4, 1);
    repeat (12) @(negedge clk);
    on_count(3, 1536, 1152, "R6 prescaler 1");
    wr(5, 8'hFF);
    repeat (3) @(negedge clk);
    on_count(3, 1536, 6, "R6 duty FF");
    // R7 pin inputs
    for (int a = 6; a <= 9; a++) wr(a, 8'h55);
    ext_lvl = 16'hA5C3;
    repeat (5) @(negedge clk);
    rd(0, 8'hC3, "R7 input reg 0"); rd(1, 8'hA5, "R7 input reg 1");
    wr(6, 8'h54);
    repeat (5) @(negedge clk);
    rd(0, 8'hC2, "R7 driven pin reads low");
    ext_lvl = 16'h5A3C;
    repeat (5) @(negedge clk);
    rd(1, 8'h5A, "R7 new level");
    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule